// File: doc/BRIEF.md
# Test Program Sequencer

The sequencer stores a small set of fixed test programs and runs one of them on request. Each program is a short list of test primitives. It starts a core's self-test, sets a block's mode, polls a block's status until its test has ended, reads a block's pass flag into a result register, branches on a collected result, and ends. Primitives that touch another block leave the sequencer as tokens on a request/response port toward a control-ring node. Writes complete when the node accepts them. A read completes when the node returns one response.

Software or a test controller loads a program number. It then watches the done flag, which is low while the program runs and high once it has finished. Then it reads the result register. The order of the primitives inside a program decides the schedule. Starting two self-tests before the first poll runs them in parallel. Polling the first before starting the second runs them one after the other.

Top module: `prog_seq`

## Requirements
- R1: After reset, done_o is 0, result_o is 0 and req_valid_o is 0.
- R2: Loading a program number below PROG_CNT (default 13) while idle starts that program. One cycle later done_o is 0 and result_o is 0.
- R3: A load while a program runs has no effect on the running program. A load of a number of PROG_CNT or more while idle is ignored, and done_o and result_o keep their values.
- R4: Start writes data 0x01 to register code 0 (control) of its target, and Configure writes register code 1 (mode), optionally with req_bcast_o set. A write completes on the cycle req_valid_o and req_ready_i are both high. An unaccepted request holds its fields until it is accepted or the program aborts.
- R5: Wait reads register code 2 (status) of its target again and again until response bit 0 (test ended) is 1, then moves on.
- R6: Collect reads register code 3 (result) of its target and stores response bit 0 (pass) in the result bit that the instruction names.
- R7: Jump moves to its label when the named result bit is 0, otherwise to the next instruction. It issues no token.
- R8: End sets done_o to 1. While done_o is 1 no request is issued.
- R9: Program 0 starts the memory tests at targets 1 and 2, then waits on 1, then waits on 2, then collects 1 into result bit 0 and 2 into result bit 1.
- R10: Program 1 starts target 1, waits on it, then starts target 2 and waits on it, then collects as in program 0.
- R11: Program 2 broadcasts mode data 0x01 with target field 0, then starts, waits on and collects target 1 into bit 0. If bit 0 is 0 it ends. Otherwise it starts, waits on and collects target 3 into bit 2.
- R12: A Wait not satisfied within poll_limit_i cycles ends the program, sets result bit 7 (timeout) and sets done_o.
- R13: A poll_limit_i of 0 disables the timeout.
- R14: Programs 3 to PROG_CNT-1 are empty. They end at once with result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_load_i | input | 1 | Load strobe for the program number |
| sel_data_i | input | PROG_W | Program number |
| poll_limit_i | input | LIM_W | Cycle limit for one Wait, 0 disables |
| done_o | output | 1 | Program finished |
| result_o | output | RES_W | Collected pass flags, timeout in the top bit |
| req_valid_o | output | 1 | Token request valid |
| req_ready_i | input | 1 | Ring node accepts the token |
| req_write_o | output | 1 | 1 write, 0 read |
| req_bcast_o | output | 1 | Write goes to all blocks |
| req_tgt_o | output | TGT_W | Target block address |
| req_reg_o | output | 2 | Register code: 0 control, 1 mode, 2 status, 3 result |
| req_data_o | output | ARG_W | Write data |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | ARG_W | Read response data, bit 0 used |

## Verification
The hardest case to reach is a Wait that times out while a stalled request or a late response is in flight. The response from the ring node can then arrive after the program has already ended. The bench's ring-node model keeps one target's test-end bit clear forever and stalls acceptance every third cycle. This drives the sequencer into its abort path in both the issue and the response phase. The same model lets a reload land mid-run and checks that the token stream of the running program continues unchanged.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  localparam int unsigned TGT_W = 4;
  localparam int unsigned ARG_W = 8;
  localparam int unsigned PC_W  = 4;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_MODE = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_RES  = 2'd3;

  localparam logic [TGT_W-1:0] TGT_MEM_A = TGT_W'(1);
  localparam logic [TGT_W-1:0] TGT_MEM_B = TGT_W'(2);
  localparam logic [TGT_W-1:0] TGT_CORE  = TGT_W'(3);

  typedef enum logic [2:0] {
    OP_START, OP_CONFIG, OP_COLLECT, OP_WAIT, OP_JUMP, OP_END
  } op_e;

  typedef struct packed {
    op_e              op;
    logic             bcast;
    logic [TGT_W-1:0] tgt;
    logic [ARG_W-1:0] arg;   // write data, result bit index
    logic [PC_W-1:0]  dst;   // jump label
  } instr_t;

  function automatic instr_t mk_instr(op_e op, logic bc, logic [TGT_W-1:0] tgt,
                                      logic [ARG_W-1:0] arg, logic [PC_W-1:0] dst);
    instr_t i;
    i.op = op; i.bcast = bc; i.tgt = tgt; i.arg = arg; i.dst = dst;
    return i;
  endfunction
endpackage

// File: rtl/prog_seq_rom.sv
module prog_seq_rom
  import prog_seq_pkg::*;
#(
  parameter int unsigned PROG_W = 4
) (
  input  logic [PROG_W-1:0] prog_i,
  input  logic [PC_W-1:0]   pc_i,
  output instr_t            instr_o
);
  localparam logic [ARG_W-1:0] GO = ARG_W'(1);

  always_comb begin
    instr_o = mk_instr(OP_END, 1'b0, '0, '0, '0);
    case (prog_i)
      PROG_W'(0): case (pc_i) // parallel memory tests
        PC_W'(0): instr_o = mk_instr(OP_START,   1'b0, TGT_MEM_A, GO, '0);
        PC_W'(1): instr_o = mk_instr(OP_START,   1'b0, TGT_MEM_B, GO, '0);
        PC_W'(2): instr_o = mk_instr(OP_WAIT,    1'b0, TGT_MEM_A, '0, '0);
        PC_W'(3): instr_o = mk_instr(OP_WAIT,    1'b0, TGT_MEM_B, '0, '0);
        PC_W'(4): instr_o = mk_instr(OP_COLLECT, 1'b0, TGT_MEM_A, ARG_W'(0), '0);
        PC_W'(5): instr_o = mk_instr(OP_COLLECT, 1'b0, TGT_MEM_B, ARG_W'(1), '0);
        default: ;
      endcase
      PROG_W'(1): case (pc_i) // serial memory tests
        PC_W'(0): instr_o = mk_instr(OP_START,   1'b0, TGT_MEM_A, GO, '0);
        PC_W'(1): instr_o = mk_instr(OP_WAIT,    1'b0, TGT_MEM_A, '0, '0);
        PC_W'(2): instr_o = mk_instr(OP_START,   1'b0, TGT_MEM_B, GO, '0);
        PC_W'(3): instr_o = mk_instr(OP_WAIT,    1'b0, TGT_MEM_B, '0, '0);
        PC_W'(4): instr_o = mk_instr(OP_COLLECT, 1'b0, TGT_MEM_A, ARG_W'(0), '0);
        PC_W'(5): instr_o = mk_instr(OP_COLLECT, 1'b0, TGT_MEM_B, ARG_W'(1), '0);
        default: ;
      endcase
      PROG_W'(2): case (pc_i) // skip core test when memory fails
        PC_W'(0): instr_o = mk_instr(OP_CONFIG,  1'b1, '0,        GO, '0);
        PC_W'(1): instr_o = mk_instr(OP_START,   1'b0, TGT_MEM_A, GO, '0);
        PC_W'(2): instr_o = mk_instr(OP_WAIT,    1'b0, TGT_MEM_A, '0, '0);
        PC_W'(3): instr_o = mk_instr(OP_COLLECT, 1'b0, TGT_MEM_A, ARG_W'(0), '0);
        PC_W'(4): instr_o = mk_instr(OP_JUMP,    1'b0, '0,        ARG_W'(0), PC_W'(8));
        PC_W'(5): instr_o = mk_instr(OP_START,   1'b0, TGT_CORE,  GO, '0);
        PC_W'(6): instr_o = mk_instr(OP_WAIT,    1'b0, TGT_CORE,  '0, '0);
        PC_W'(7): instr_o = mk_instr(OP_COLLECT, 1'b0, TGT_CORE,  ARG_W'(2), '0);
        default: ;
      endcase
      default: ;
    endcase
  end
endmodule

// File: rtl/prog_seq_poll_timer.sv
module prog_seq_poll_timer #(
  parameter int unsigned LIM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             expired_o
);
  logic [LIM_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || clear_i) cnt_q <= '0;
    else if (cnt_q != '1)       cnt_q <= cnt_q + LIM_W'(1);
  end

  assign expired_o = run_i && (limit_i != '0) && (cnt_q >= limit_i - LIM_W'(1));
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int unsigned PROG_CNT = 13,
  parameter int unsigned PROG_W   = $clog2(PROG_CNT),
  parameter int unsigned LIM_W    = 16,
  parameter int unsigned RES_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_load_i,
  input  logic [PROG_W-1:0] sel_data_i,
  input  logic [LIM_W-1:0] poll_limit_i,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             req_valid_o,
  input  logic             req_ready_i,
  output logic             req_write_o,
  output logic             req_bcast_o,
  output logic [TGT_W-1:0] req_tgt_o,
  output logic [1:0]       req_reg_o,
  output logic [ARG_W-1:0] req_data_o,
  input  logic             rsp_valid_i,
  input  logic [ARG_W-1:0] rsp_data_i
);
  localparam int unsigned IDX_W = $clog2(RES_W);

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_RSP} st_e;

  st_e              st_q;
  logic [PROG_W-1:0] prog_q;
  logic [PC_W-1:0]  pc_q;
  logic             done_q;
  logic [RES_W-1:0] res_q;
  instr_t           instr;
  logic             run_w, in_wait, wait_hit, expired, tmo, accept, sel_ok;
  logic [IDX_W-1:0] idx;
  logic             unused_rsp;

  assign unused_rsp = ^rsp_data_i[ARG_W-1:1];

  prog_seq_rom #(.PROG_W(PROG_W)) i_rom (
    .prog_i (prog_q),
    .pc_i   (pc_q),
    .instr_o(instr)
  );

  assign run_w    = (st_q != ST_IDLE);
  assign in_wait  = run_w && (instr.op == OP_WAIT);
  assign wait_hit = in_wait && (st_q == ST_RSP) && rsp_valid_i && rsp_data_i[0];

  prog_seq_poll_timer #(.LIM_W(LIM_W)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (in_wait),
    .clear_i  (wait_hit),
    .limit_i  (poll_limit_i),
    .expired_o(expired)
  );

  assign tmo    = expired && !wait_hit;
  assign idx    = instr.arg[IDX_W-1:0];
  assign sel_ok = sel_load_i && ({1'b0, sel_data_i} < (PROG_W+1)'(PROG_CNT));

  always_comb begin
    req_valid_o = 1'b0;
    req_reg_o   = REG_RES;
    if (st_q == ST_ISSUE && !tmo) begin
      case (instr.op)
        OP_START, OP_CONFIG, OP_COLLECT, OP_WAIT: req_valid_o = 1'b1;
        default: ;
      endcase
    end
    case (instr.op)
      OP_START:  req_reg_o = REG_CTRL;
      OP_CONFIG: req_reg_o = REG_MODE;
      OP_WAIT:   req_reg_o = REG_STAT;
      default:   req_reg_o = REG_RES;
    endcase
  end

  assign req_write_o = (instr.op == OP_START) || (instr.op == OP_CONFIG);
  assign req_bcast_o = (instr.op == OP_CONFIG) && instr.bcast;
  assign req_tgt_o   = instr.tgt;
  assign req_data_o  = instr.arg;
  assign accept      = req_valid_o && req_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      prog_q <= '0;
      pc_q   <= '0;
      done_q <= 1'b0;
      res_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (sel_ok) begin
          prog_q <= sel_data_i;
          pc_q   <= '0;
          done_q <= 1'b0;
          res_q  <= '0;
          st_q   <= ST_ISSUE;
        end
        ST_ISSUE: if (tmo) begin
          res_q[RES_W-1] <= 1'b1;
          done_q         <= 1'b1;
          st_q           <= ST_IDLE;
        end else begin
          case (instr.op)
            OP_START, OP_CONFIG: if (accept) pc_q <= pc_q + PC_W'(1);
            OP_COLLECT, OP_WAIT: if (accept) st_q <= ST_RSP;
            OP_JUMP: pc_q <= res_q[idx] ? pc_q + PC_W'(1) : instr.dst;
            default: begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
          endcase
        end
        ST_RSP: if (tmo) begin
          res_q[RES_W-1] <= 1'b1;
          done_q         <= 1'b1;
          st_q           <= ST_IDLE;
        end else if (rsp_valid_i) begin
          st_q <= ST_ISSUE;
          if (instr.op == OP_COLLECT) begin
            res_q[idx] <= rsp_data_i[0];
            pc_q       <= pc_q + PC_W'(1);
          end else if (rsp_data_i[0]) begin
            pc_q <= pc_q + PC_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int unsigned PROG_CNT = 13,
  parameter int unsigned PROG_W   = 4,
  parameter int unsigned RES_W    = 8,
  parameter int unsigned TGT_W    = 4,
  parameter int unsigned ARG_W    = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_load_i,
  input logic [PROG_W-1:0] sel_data_i,
  input logic              run_i,
  input logic [PROG_W-1:0] prog_i,
  input logic              done_o,
  input logic [RES_W-1:0]  result_o,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic              req_write_o,
  input logic              req_bcast_o,
  input logic [TGT_W-1:0]  req_tgt_o,
  input logic [1:0]        req_reg_o,
  input logic [ARG_W-1:0]  req_data_o
);
  logic sel_in_range;
  assign sel_in_range = ({1'b0, sel_data_i} < (PROG_W+1)'(PROG_CNT));

  p_start_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && sel_load_i && sel_in_range) |=> (run_i && !done_o && result_o == '0));

  p_busy_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && sel_load_i) |=> $stable(prog_i));

  p_bad_sel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && sel_load_i && !sel_in_range) |=> (!run_i && $stable(done_o) && $stable(result_o)));

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (done_o || (req_valid_o && $stable(req_write_o) &&
      $stable(req_bcast_o) && $stable(req_tgt_o) && $stable(req_reg_o) && $stable(req_data_o))));

  p_bcast_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_bcast_o) |-> req_write_o);

  p_done_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!req_valid_o && !run_i));

  p_tmo_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(result_o[RES_W-1]) |-> done_o);
endmodule

bind prog_seq prog_seq_chk #(
  .PROG_CNT(PROG_CNT), .PROG_W(PROG_W), .RES_W(RES_W),
  .TGT_W(prog_seq_pkg::TGT_W), .ARG_W(prog_seq_pkg::ARG_W)
) i_prog_seq_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_load_i(sel_load_i), .sel_data_i(sel_data_i),
  .run_i(run_w), .prog_i(prog_q), .done_o(done_o), .result_o(result_o),
  .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_write_o(req_write_o),
  .req_bcast_o(req_bcast_o), .req_tgt_o(req_tgt_o), .req_reg_o(req_reg_o),
  .req_data_o(req_data_o)
);

// File: tb/test_prog_seq.sv
module test_prog_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_load_i = 1'b0;
  logic [3:0] sel_data_i = '0;
  logic [15:0] poll_limit_i = 16'd1000;
  logic       done_o, req_valid_o, req_write_o, req_bcast_o;
  logic       req_ready_i = 1'b0, rsp_valid_i = 1'b0;
  logic [7:0] result_o, req_data_o, rsp_data_i = '0;
  logic [3:0] req_tgt_o;
  logic [1:0] req_reg_o;

  prog_seq i_prog_seq (.*);

  always #5 clk_i = ~clk_i;

  int n_vec = 0, n_err = 0, cyc = 0;
  int dur[4], rem[4];
  bit ended[4], pass[4];
  bit pend = 0;
  logic [7:0] pend_data;
  logic [15:0] exp_q[$];
  logic [15:0] last_tok = '1;
  logic [15:0] watch_tok = '1;
  int watch_cyc = -1;

  function automatic logic [15:0] tok(bit w, bit bc, int t, int r, int d);
    return {w, bc, 4'(t), 2'(r), (w ? 8'(d) : 8'h00)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ring node model and per-clock comparison
  initial forever begin
    @(negedge clk_i);
    cyc++;
    for (int t = 0; t < 4; t++)
      if (rem[t] > 0) begin rem[t]--; if (rem[t] == 0) ended[t] = 1; end
    if (pend) begin rsp_valid_i = 1'b1; rsp_data_i = pend_data; pend = 0; end
    else rsp_valid_i = 1'b0;
    if (rst_ni) chk(!(done_o && req_valid_o), "R8 request while done", req_valid_o, 0);
    req_ready_i = (cyc % 3) != 1;
    if (rst_ni && req_valid_o && req_ready_i) begin
      logic [15:0] a;
      a = tok(req_write_o, req_bcast_o, int'(req_tgt_o), int'(req_reg_o), int'(req_data_o));
      if (a == watch_tok && watch_cyc < 0) watch_cyc = cyc;
      if (exp_q.size() > 0 && a == exp_q[0]) begin
        void'(exp_q.pop_front());
        last_tok = a;
        chk(1, "R4", a, a);
      end else
        chk(a == last_tok && a[9:8] == 2'd2, "R4/R5 token order", a,
            exp_q.size() > 0 ? exp_q[0] : 16'hffff);
      if (req_write_o && req_reg_o == 2'd0 && req_data_o[0]) begin
        ended[req_tgt_o[1:0]] = 0;
        rem[req_tgt_o[1:0]] = dur[req_tgt_o[1:0]];
      end
      if (!req_write_o) begin
        pend = 1;
        pend_data = {7'd0, (req_reg_o == 2'd2) ? ended[req_tgt_o[1:0]] : pass[req_tgt_o[1:0]]};
      end
    end
  end

  task automatic load(input int p, input bit valid);
    @(negedge clk_i);
    sel_load_i = 1'b1; sel_data_i = 4'(p);
    @(negedge clk_i);
    sel_load_i = 1'b0;
    if (valid) begin
      chk(done_o == 1'b0, "R2 done cleared", done_o, 0);
      chk(result_o == 8'h00, "R2 result cleared", result_o, 0);
    end
  endtask

  task automatic finish_run(input int exp_res, input int bound, input string req);
    int n = 0;
    while (!done_o && n < bound) begin @(negedge clk_i); n++; end
    chk(done_o == 1'b1, {req, " done"}, done_o, 1);
    chk(result_o == 8'(exp_res), {req, " result"}, result_o, exp_res);
    chk(exp_q.size() == 0, {req, " tokens left"}, exp_q.size(), 0);
    last_tok = '1;
  endtask

  task automatic set_mem(input int d1, input bit p1, input int d2, input bit p2,
                         input int d3, input bit p3);
    dur[1] = d1; pass[1] = p1; dur[2] = d2; pass[2] = p2; dur[3] = d3; pass[3] = p3;
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    for (int t = 0; t < 4; t++) begin dur[t] = 5; rem[t] = 0; ended[t] = 0; pass[t] = 1; end
    repeat (3) @(negedge clk_i);
    chk(done_o == 0 && result_o == 0 && req_valid_o == 0, "R1 reset state",
        {done_o, result_o, req_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o == 0 && result_o == 0 && req_valid_o == 0, "R1 after release",
        {done_o, result_o, req_valid_o}, 0);

    // R9 parallel, both pass
    set_mem(20, 1, 35, 1, 5, 1);
    exp_q = '{tok(1,0,1,0,1), tok(1,0,2,0,1), tok(0,0,1,2,0), tok(0,0,2,2,0),
              tok(0,0,1,3,0), tok(0,0,2,3,0)};
    load(0, 1);
    finish_run(8'h03, 500, "R9");

    // R6 first memory fails
    set_mem(12, 0, 8, 1, 5, 1);
    exp_q = '{tok(1,0,1,0,1), tok(1,0,2,0,1), tok(0,0,1,2,0), tok(0,0,2,2,0),
              tok(0,0,1,3,0), tok(0,0,2,3,0)};
    load(0, 1);
    finish_run(8'h02, 500, "R6");

    // R10 serial, reload mid-run ignored (R3)
    set_mem(10, 1, 15, 1, 5, 1);
    exp_q = '{tok(1,0,1,0,1), tok(0,0,1,2,0), tok(1,0,2,0,1), tok(0,0,2,2,0),
              tok(0,0,1,3,0), tok(0,0,2,3,0)};
    load(1, 1);
    repeat (4) @(negedge clk_i);
    load(0, 0);
    finish_run(8'h03, 500, "R10/R3");

    // R11 conditional, memory passes, core tested
    set_mem(9, 1, 5, 1, 14, 1);
    exp_q = '{tok(1,1,0,1,1), tok(1,0,1,0,1), tok(0,0,1,2,0), tok(0,0,1,3,0),
              tok(1,0,3,0,1), tok(0,0,3,2,0), tok(0,0,3,3,0)};
    load(2, 1);
    finish_run(8'h05, 500, "R11");

    // R7 jump skips core on failing memory
    set_mem(9, 0, 5, 1, 14, 1);
    exp_q = '{tok(1,1,0,1,1), tok(1,0,1,0,1), tok(0,0,1,2,0), tok(0,0,1,3,0)};
    load(2, 1);
    finish_run(8'h00, 500, "R7");
    repeat (20) @(negedge clk_i);
    chk(done_o == 1 && result_o == 0, "R7 no core test", result_o, 0);

    // R3 out-of-range program number ignored
    set_mem(9, 1, 9, 1, 9, 1);
    exp_q = '{tok(1,0,1,0,1), tok(1,0,2,0,1), tok(0,0,1,2,0), tok(0,0,2,2,0),
              tok(0,0,1,3,0), tok(0,0,2,3,0)};
    load(0, 1);
    finish_run(8'h03, 500, "R9 again");
    load(13, 0);
    repeat (10) @(negedge clk_i);
    chk(done_o == 1'b1, "R3 bad number done kept", done_o, 1);
    chk(result_o == 8'h03, "R3 bad number result kept", result_o, 8'h03);

    // R12 timeout on second memory
    poll_limit_i = 16'd40;
    set_mem(6, 1, -1, 1, 5, 1);
    watch_tok = tok(0,0,2,2,0); watch_cyc = -1;
    exp_q = '{tok(1,0,1,0,1), tok(1,0,2,0,1), tok(0,0,1,2,0), tok(0,0,2,2,0)};
    load(0, 1);
    finish_run(8'h80, 500, "R12");
    chk((cyc - watch_cyc) >= 38 && (cyc - watch_cyc) <= 41, "R12 wait length",
        cyc - watch_cyc, 40);
    repeat (5) @(negedge clk_i);

    // R14 empty program, clears timeout flag (R2)
    exp_q = {};
    load(5, 1);
    finish_run(8'h00, 20, "R14");

    // R13 limit 0 disables timeout
    poll_limit_i = 16'd0;
    set_mem(300, 1, 300, 0, 5, 1);
    exp_q = '{tok(1,0,1,0,1), tok(0,0,1,2,0), tok(1,0,2,0,1), tok(0,0,2,2,0),
              tok(0,0,1,3,0), tok(0,0,2,3,0)};
    load(1, 1);
    finish_run(8'h01, 2000, "R13");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule